// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block computes one of ten integer operations on two operand words, selected by a 4-bit operation code. The operations are signed and unsigned addition, signed and unsigned subtraction, four bitwise functions (AND, OR, XOR, NOR), and signed and unsigned less-than comparison. Alongside the result word it reports a carry-out, a signed overflow indication and a zero indication. The block is meant to sit in the execute stage of an integer pipeline. Operand preparation happens upstream: immediate extension, register read and instruction decode are all done before the operands reach it.

The arithmetic core is one adder. It is built from lookahead blocks whose carries ripple from block to block. Subtraction feeds the adder the bitwise inverse of the second operand and forces the carry-in to one. The comparison modes take their answer from that same subtraction. Signed comparison corrects the sign of the difference with the overflow bit. Unsigned comparison uses the inverse of the carry-out. By default, the result and the three flags are captured in an output register stage, so results appear one clock after the operands are presented. A parameter selects a purely combinational output instead.

Top module: `int_alu`

## Requirements
- R1: Operation codes 0 (signed add) and 1 (unsigned add) give `res_o` = A + B modulo 2^32. `carry_o` is the carry out of bit 31.
- R2: Operation codes 2 (signed subtract) and 3 (unsigned subtract) give `res_o` = A − B modulo 2^32, computed as A + ~B + 1. `carry_o` is the carry out of that sum, so it is 1 exactly when A ≥ B as unsigned numbers.
- R3: `ovf_o` can be 1 only for codes 0 and 2. For those two codes it equals the carry into bit 31 XOR the carry out of bit 31. As a result, adding operands of opposite sign never flags overflow, and subtracting operands of equal sign never flags it either. For every other code `ovf_o` is 0.
- R4: Codes 4, 5, 6 and 7 give bitwise A AND B, A OR B, A XOR B and NOR(A, B). For these codes `carry_o` and `ovf_o` are 0.
- R5: Code 10 gives `res_o` = 1 when A < B as signed two's-complement numbers, and 0 otherwise. The bit is zero-extended to 32 bits, and it is correct even when A − B overflows. For this code `carry_o` is 0.
- R6: Code 11 gives `res_o` = 1 when A < B as unsigned numbers, and 0 otherwise, zero-extended. For this code `carry_o` is 0.
- R7: `zero_o` is 1 exactly when every bit of `res_o` is 0. This holds for all codes.
- R8: The unused codes 8, 9, 12, 13, 14 and 15 give `res_o` = 0, with `carry_o` = 0 and `ovf_o` = 0.
- R9: With the default registered output, the outputs follow the inputs after exactly one rising clock edge and hold between edges. While `rst_n` is low, `res_o`, `carry_o` and `ovf_o` are 0 and `zero_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa_i | input | 32 | First operand A |
| opb_i | input | 32 | Second operand B |
| mode_i | input | 4 | Operation code |
| res_o | output | 32 | Result word |
| carry_o | output | 1 | Adder carry-out for add and subtract codes |
| ovf_o | output | 1 | Signed overflow for codes 0 and 2 |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
The hardest cases to reach are the operand pairs at the edge of the signed range. Examples are a signed comparison whose internal subtraction overflows, such as the most negative value against a positive number, and sums that land exactly on 0x7FFFFFFF or wrap past it. Uniformly random operands almost never produce these. The stimulus therefore draws each operand from a small pool of boundary values (zero, one, all ones, the most positive and most negative numbers) about half the time. It also forces equal operands regularly, and it runs directed vectors such as 0x7FFFFFFF + 1 and 0x80000000 − 1 through every operation code.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd10,
    OP_SLTU = 4'd11
  } alu_op_e;

  // bitwise function select, matches the two low code bits of 4..7
  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_XOR = 2'd2,
    LF_NOR = 2'd3
  } logic_fn_e;

  typedef struct packed {
    logic      use_adder;   // result comes from the adder
    logic      invert_b;    // subtract: ~B and carry-in 1
    logic      ovf_enable;  // signed add / subtract report overflow
    logic      is_cmp;      // set-less-than
    logic      cmp_signed;  // signed comparison
    logic      is_logic;    // bitwise function
    logic_fn_e lfn;
  } alu_ctl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0] mode_i,
  output alu_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '0;
    case (mode_i)
      OP_ADD: begin
        ctl_o.use_adder  = 1'b1;
        ctl_o.ovf_enable = 1'b1;
      end
      OP_ADDU: begin
        ctl_o.use_adder  = 1'b1;
      end
      OP_SUB: begin
        ctl_o.use_adder  = 1'b1;
        ctl_o.invert_b   = 1'b1;
        ctl_o.ovf_enable = 1'b1;
      end
      OP_SUBU: begin
        ctl_o.use_adder  = 1'b1;
        ctl_o.invert_b   = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOR: begin
        ctl_o.is_logic   = 1'b1;
        ctl_o.lfn        = logic_fn_e'(mode_i[1:0]);
      end
      OP_SLT: begin
        ctl_o.invert_b   = 1'b1;
        ctl_o.is_cmp     = 1'b1;
        ctl_o.cmp_signed = 1'b1;
      end
      OP_SLTU: begin
        ctl_o.invert_b   = 1'b1;
        ctl_o.is_cmp     = 1'b1;
      end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_cla_adder.sv
// Adder built from lookahead blocks of BLK bits; block carries ripple.
module alu_cla_adder #(
  parameter int WIDTH = 32,
  parameter int BLK   = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             cmsb_o   // carry into the top bit
);

  localparam int NBLK = WIDTH / BLK;

  logic [NBLK:0]  blk_c;
  logic [WIDTH:0] bit_c;

  assign blk_c[0]     = cin_i;
  assign bit_c[WIDTH] = blk_c[NBLK];

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    logic [BLK-1:0] g;
    logic [BLK-1:0] p;
    logic [BLK:0]   bc;

    assign g = a_i[k*BLK +: BLK] & b_i[k*BLK +: BLK];
    assign p = a_i[k*BLK +: BLK] ^ b_i[k*BLK +: BLK];

    // sum-of-products lookahead for every carry inside the block
    always_comb begin
      logic acc;
      logic run;
      bc[0] = blk_c[k];
      for (int i = 0; i < BLK; i++) begin
        acc = 1'b0;
        run = 1'b1;
        for (int j = i; j >= 0; j--) begin
          acc = acc | (run & g[j]);
          run = run & p[j];
        end
        bc[i+1] = acc | (run & blk_c[k]);
      end
    end

    assign sum_o[k*BLK +: BLK] = p ^ bc[BLK-1:0];
    assign bit_c[k*BLK +: BLK] = bc[BLK-1:0];
    assign blk_c[k+1]          = bc[BLK];
  end

  assign cout_o = bit_c[WIDTH];
  assign cmsb_o = bit_c[WIDTH-1];

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic_fn_e        fn_i,
  output logic [WIDTH-1:0] y_o
);

  always_comb begin
    case (fn_i)
      LF_AND:  y_o = a_i & b_i;
      LF_OR:   y_o = a_i | b_i;
      LF_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

endmodule

// File: rtl/alu_result_sel.sv
// Picks the result word and forms carry, overflow and zero.
module alu_result_sel
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_ctl_t         ctl_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             cout_i,
  input  logic             cmsb_i,
  input  logic [WIDTH-1:0] lgc_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o
);

  localparam int MSB = WIDTH - 1;

  logic raw_ovf;
  logic less;

  assign raw_ovf = cmsb_i ^ cout_i;
  assign less    = ctl_i.cmp_signed ? (sum_i[MSB] ^ raw_ovf) : ~cout_i;

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    ovf_o   = 1'b0;
    if (ctl_i.is_logic) begin
      res_o = lgc_i;
    end else if (ctl_i.is_cmp) begin
      res_o = {{(WIDTH-1){1'b0}}, less};
    end else if (ctl_i.use_adder) begin
      res_o   = sum_i;
      carry_o = cout_i;
      ovf_o   = ctl_i.ovf_enable & raw_ovf;
    end
  end

  assign zero_o = ~|res_o;

endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int BLK     = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [3:0]       mode_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o
);

  alu_ctl_t         ctl;
  logic [WIDTH-1:0] add_b;
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic             cmsb;
  logic [WIDTH-1:0] lgc;
  logic [WIDTH-1:0] res_d;
  logic             carry_d;
  logic             ovf_d;
  logic             zero_d;

  alu_decode u_dec (
    .mode_i (mode_i),
    .ctl_o  (ctl)
  );

  assign add_b = ctl.invert_b ? ~opb_i : opb_i;

  alu_cla_adder #(.WIDTH(WIDTH), .BLK(BLK)) u_add (
    .a_i    (opa_i),
    .b_i    (add_b),
    .cin_i  (ctl.invert_b),
    .sum_o  (sum),
    .cout_o (cout),
    .cmsb_o (cmsb)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_lgc (
    .a_i  (opa_i),
    .b_i  (opb_i),
    .fn_i (ctl.lfn),
    .y_o  (lgc)
  );

  alu_result_sel #(.WIDTH(WIDTH)) u_sel (
    .ctl_i   (ctl),
    .sum_i   (sum),
    .cout_i  (cout),
    .cmsb_i  (cmsb),
    .lgc_i   (lgc),
    .res_o   (res_d),
    .carry_o (carry_d),
    .ovf_o   (ovf_d),
    .zero_o  (zero_d)
  );

  if (REG_OUT) begin : g_reg
    logic [WIDTH-1:0] res_q;
    logic             carry_q;
    logic             ovf_q;
    logic             zero_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q   <= '0;
        carry_q <= 1'b0;
        ovf_q   <= 1'b0;
        zero_q  <= 1'b1;
      end else begin
        res_q   <= res_d;
        carry_q <= carry_d;
        ovf_q   <= ovf_d;
        zero_q  <= zero_d;
      end
    end

    assign res_o   = res_q;
    assign carry_o = carry_q;
    assign ovf_o   = ovf_q;
    assign zero_o  = zero_q;
  end else begin : g_comb
    assign res_o   = res_d;
    assign carry_o = carry_d;
    assign ovf_o   = ovf_d;
    assign zero_o  = zero_d;
  end

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [3:0]       mode_i,
  input logic [WIDTH-1:0] res_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             zero_o
);

  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q;
  logic [3:0]       m_q;
  logic             ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      m_q  <= '0;
      ok_q <= 1'b0;
    end else begin
      a_q  <= opa_i;
      b_q  <= opb_i;
      m_q  <= mode_i;
      ok_q <= 1'b1;
    end
  end

  logic [WIDTH-1:0] am;
  logic [WIDTH-1:0] bm;
  logic [3:0]       m;
  logic             vld;
  logic             unused_code;

  assign am  = REG_OUT ? a_q : opa_i;
  assign bm  = REG_OUT ? b_q : opb_i;
  assign m   = REG_OUT ? m_q : mode_i;
  assign vld = REG_OUT ? ok_q : 1'b1;
  assign unused_code = (m == 4'd8) || (m == 4'd9) || (m >= 4'd12);

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n) vld && (m == 4'd0 || m == 4'd1) |-> res_o == am + bm); // R1
  AST_SUB_DIFF: assert property (@(posedge clk) disable iff (!rst_n) vld && (m == 4'd2 || m == 4'd3) |-> res_o == am - bm); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) vld && !(m == 4'd0 || m == 4'd2) |-> !ovf_o); // R3
  AST_OPPOSITE_SIGN_ADD: assert property (@(posedge clk) disable iff (!rst_n) vld && m == 4'd0 && (am[WIDTH-1] != bm[WIDTH-1]) |-> !ovf_o); // R3
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n) vld && (m >= 4'd4 && m <= 4'd7) |-> !carry_o); // R4
  AST_SLT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n) vld && m == 4'd10 |-> res_o[WIDTH-1:1] == '0 && !carry_o); // R5
  AST_SLTU_ORDER: assert property (@(posedge clk) disable iff (!rst_n) vld && m == 4'd11 |-> res_o == {{(WIDTH-1){1'b0}}, (am < bm)}); // R6
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) vld |-> zero_o == (res_o == '0)); // R7
  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) vld && unused_code |-> res_o == '0 && !carry_o && !ovf_o); // R8

endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .opa_i   (opa_i),
  .opb_i   (opb_i),
  .mode_i  (mode_i),
  .res_o   (res_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o),
  .zero_o  (zero_o)
);

// File: tb/sim_int_alu.sv
module sim_int_alu;

  logic        clk;
  logic        rst_n;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [3:0]  mode;
  logic [31:0] res;
  logic        carry;
  logic        ovf;
  logic        zero;

  int checks;
  int fails;
  bit done;

  int_alu u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .opa_i   (opa),
    .opb_i   (opb),
    .mode_i  (mode),
    .res_o   (res),
    .carry_o (carry),
    .ovf_o   (ovf),
    .zero_o  (zero)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference model written from the requirements
  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m,
                       output logic [31:0] r, output logic c, output logic v);
    logic [32:0] t;
    r = '0; c = 1'b0; v = 1'b0;
    case (m)
      4'd0, 4'd1: begin
        t = {1'b0, a} + {1'b0, b};
        r = t[31:0]; c = t[32];
        if (m == 4'd0) v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      4'd2, 4'd3: begin
        r = a - b; c = (a >= b);
        if (m == 4'd2) v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = ~(a | b);
      4'd10: r = {31'd0, ($signed(a) < $signed(b))};
      4'd11: r = {31'd0, (a < b)};
      default: r = '0;
    endcase
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3: return "R2";
      4'd4, 4'd5, 4'd6, 4'd7: return "R4";
      4'd10: return "R5";
      4'd11: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  // called at a falling edge; drives, waits one full cycle, compares
  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m);
    logic [31:0] er;
    logic ec, ev;
    model(a, b, m, er, ec, ev);
    opa = a; opb = b; mode = m;
    @(negedge clk);
    checks++;
    if (res !== er || carry !== ec) begin
      fails++;
      $display("FAIL %s mode=%0d a=%h b=%h: res=%h carry=%b expected res=%h carry=%b",
               tag_of(m), m, a, b, res, carry, er, ec);
    end
    checks++;
    if (ovf !== ev) begin
      fails++;
      $display("FAIL R3 mode=%0d a=%h b=%h: ovf=%b expected %b", m, a, b, ovf, ev);
    end
    checks++;
    if (zero !== (er == 32'd0)) begin
      fails++;
      $display("FAIL R7 mode=%0d a=%h b=%h: zero=%b expected %b", m, a, b, zero, (er == 32'd0));
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, cycles=%0d expected fewer", cyc);
    finish_up();
  end

  initial begin
    logic [31:0] seed_val;
    logic [31:0] corners [6];
    checks = 0; fails = 0; done = 1'b0;
    seed_val = $urandom(32'd20240611);
    rst_n = 1'b0; opa = 32'h1234_5678; opb = 32'h0F0F_0F0F; mode = 4'd0;
    @(negedge clk);
    @(negedge clk);
    // R9 reset state
    checks++;
    if (res !== 32'd0 || carry !== 1'b0 || ovf !== 1'b0 || zero !== 1'b1) begin
      fails++;
      $display("FAIL R9 reset: res=%h c=%b v=%b z=%b expected 0 0 0 1", res, carry, ovf, zero);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run(32'h7FFF_FFFF, 32'h0000_0001, 4'd0);  // R3 signed add overflows
    run(32'h7FFF_FFFF, 32'h0000_0001, 4'd1);  // R3 unsigned add never flags
    run(32'h8000_0000, 32'h0000_0001, 4'd2);  // R3 signed sub overflows
    run(32'h8000_0000, 32'h0000_0001, 4'd3);  // R2 unsigned sub, carry 1
    run(32'hFFFF_FFFF, 32'h0000_0001, 4'd0);  // R1 carry out, result zero
    run(32'h8000_0000, 32'hFFFF_FFFF, 4'd0);  // R1 negative overflow
    run(32'h0000_0003, 32'h0000_0005, 4'd3);  // R2 borrow, carry 0
    run(32'h8000_0000, 32'h0000_0001, 4'd10); // R5 slt with overflowing subtraction
    run(32'h7FFF_FFFF, 32'h8000_0000, 4'd10); // R5 reverse overflow case
    run(32'h8000_0000, 32'h0000_0001, 4'd11); // R6
    run(32'h1234_5678, 32'h1234_5678, 4'd2);  // R2 equal operands -> zero
    run(32'h1234_5678, 32'h1234_5678, 4'd10); // R5 equal -> 0
    run(32'h1234_5678, 32'h1234_5678, 4'd11); // R6 equal -> 0
    run(32'hF0F0_F0F0, 32'hFF00_FF00, 4'd4);  // R4
    run(32'hF0F0_F0F0, 32'hFF00_FF00, 4'd5);  // R4
    run(32'hF0F0_F0F0, 32'hFF00_FF00, 4'd6);  // R4
    run(32'hF0F0_F0F0, 32'hFF00_FF00, 4'd7);  // R4
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd8);  // R8 unused codes
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd9);
    for (int k = 12; k < 16; k++) run(32'h8000_0000, 32'h7FFF_FFFF, 4'(k));

    // every code over corner operand pairs
    corners[0] = 32'h0; corners[1] = 32'h1; corners[2] = 32'hFFFF_FFFF;
    corners[3] = 32'h7FFF_FFFF; corners[4] = 32'h8000_0000; corners[5] = 32'h8000_0001;
    for (int m = 0; m < 16; m++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          run(corners[i], corners[j], 4'(m));

    // R9 outputs hold between edges
    opa = 32'h0000_0005; opb = 32'h0000_0007; mode = 4'd0;
    @(negedge clk);
    opa = 32'h0000_0100; opb = 32'h0000_0001; mode = 4'd1;
    #2;
    checks++;
    if (res !== 32'h0000_000C) begin
      fails++;
      $display("FAIL R9 hold: res=%h expected %h", res, 32'h0000_000C);
    end
    @(negedge clk);
    checks++;
    if (res !== 32'h0000_0101) begin
      fails++;
      $display("FAIL R9 update: res=%h expected %h", res, 32'h0000_0101);
    end

    // constrained random
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] a, b;
      a = pick();
      b = ($urandom % 8 == 0) ? a : pick();
      run(a, b, 4'($urandom % 16));
    end

    finish_up();
  end

endmodule